// File: doc/BRIEF.md
# Integer Execute Unit with Operand Selection

This block is the single-cycle, purely combinational execute stage of a 32-bit base integer core. Each cycle it receives the decoded major opcode, the three-bit function field, instruction bit 30, both register operands, the program counter and the full instruction word. From these it chooses the operand sources, forms the immediate itself, runs the selected arithmetic, logic, shift or compare operation, and presents the value to be written back.

Three families of instructions are handled: register-register arithmetic, register-immediate arithmetic, and the two upper-immediate forms (a constant load and a PC-relative constant). Every other opcode is flagged as illegal and yields zero, so the surrounding pipeline can raise its exception without filtering the result.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 7'b0110011 (register form) or 7'b0010011 (immediate form), funct3 picks the operation: 3'b000 add, 3'b001 left shift, 3'b010 signed less-than, 3'b011 unsigned less-than, 3'b100 xor, 3'b101 right shift, 3'b110 or, 3'b111 and.
- R2: In the register form with funct3 3'b000, bit 30 set selects rs1 minus rs2; clear selects rs1 plus rs2.
- R3: The immediate form uses insn[31:20] sign-extended to 32 bits as second operand; for funct3 3'b000 it always adds, even when bit 30 (immediate bit 10) is set.
- R4: The shift amount is rs2[4:0] in the register form and insn[24:20] in the immediate form; upper bits are ignored and an amount of 0 returns rs1 unchanged.
- R5: For funct3 3'b101 in either form, bit 30 set selects an arithmetic right shift filling with copies of rs1[31]; clear selects a logical shift filling with zeros.
- R6: The less-than operations yield exactly 32'd1 or 32'd0; the immediate form compares against the sign-extended 12-bit immediate for both the signed and the unsigned compare.
- R7: Opcode 7'b0110111 yields {insn[31:12], 12'b0}, independent of rs1, rs2 and pc.
- R8: Opcode 7'b0010111 yields pc + {insn[31:12], 12'b0}, modulo 2^32.
- R9: Any other opcode yields a result of 0 and drives illegal_o high; illegal_o is low for the four opcodes above.
- R10: Sums and differences keep only their low 32 bits; carries and overflow are discarded without any indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 7 | Major opcode, instruction bits [6:0] |
| funct3_i | input | 3 | Function field, instruction bits [14:12] |
| bit30_i | input | 1 | Instruction bit 30 (subtract / arithmetic-shift select) |
| rs1_val_i | input | 32 | First register operand |
| rs2_val_i | input | 32 | Second register operand |
| pc_i | input | 32 | Address of the current instruction |
| insn_i | input | 32 | Full instruction word, source of the immediates |
| result_o | output | 32 | Write-back value |
| illegal_o | output | 1 | High when the opcode belongs to none of the handled families |

## Verification
The sharpest overlap is bit 30 acting at once as the subtract/arithmetic selector and as bit 10 of the 12-bit immediate. An add-immediate whose immediate has bit 10 set (for example -1 or 0x400) presents both readings in the same cycle, and the result is judged correct only if it equals the sum, while a shift-immediate with the same bit set must still shift arithmetically. A second overlap, shift decoding with a zero amount while the arithmetic fill is selected, is provoked with a negative operand and must return the operand untouched.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

  localparam int unsigned ILEN  = 32;
  localparam int unsigned OPC_W = 7;
  localparam int unsigned F3_W  = 3;

  localparam logic [OPC_W-1:0] OPC_REG   = 7'b0110011;
  localparam logic [OPC_W-1:0] OPC_IMM   = 7'b0010011;
  localparam logic [OPC_W-1:0] OPC_LUI   = 7'b0110111;
  localparam logic [OPC_W-1:0] OPC_AUIPC = 7'b0010111;

  localparam logic [F3_W-1:0] F3_ADD  = 3'b000;
  localparam logic [F3_W-1:0] F3_SLL  = 3'b001;
  localparam logic [F3_W-1:0] F3_SLT  = 3'b010;
  localparam logic [F3_W-1:0] F3_SLTU = 3'b011;
  localparam logic [F3_W-1:0] F3_XOR  = 3'b100;
  localparam logic [F3_W-1:0] F3_SR   = 3'b101;
  localparam logic [F3_W-1:0] F3_OR   = 3'b110;
  localparam logic [F3_W-1:0] F3_AND  = 3'b111;

  typedef enum logic [3:0] {
    XOP_ADD, XOP_SUB, XOP_SLL, XOP_SLT, XOP_SLTU,
    XOP_XOR, XOP_SRL, XOP_SRA, XOP_OR, XOP_AND, XOP_ZERO
  } xop_e;

  typedef enum logic [1:0] { ASRC_REG, ASRC_PC, ASRC_ZERO } asrc_e;
  typedef enum logic [1:0] { BSRC_REG, BSRC_IMM_I, BSRC_IMM_U } bsrc_e;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  logic [F3_W-1:0]  funct3_i,
  input  logic             bit30_i,
  output xop_e             xop_o,
  output asrc_e            asrc_o,
  output bsrc_e            bsrc_o,
  output logic             sub_sel_o,
  output logic             arith_sel_o,
  output logic             illegal_o
);

  logic is_reg, is_imm, is_arith;

  assign is_reg   = (opcode_i == OPC_REG);
  assign is_imm   = (opcode_i == OPC_IMM);
  assign is_arith = is_reg | is_imm;

  // Bit 30 is a subtract flag only in the register form; in the immediate
  // form it is immediate bit 10.
  assign sub_sel_o   = is_reg & bit30_i & (funct3_i == F3_ADD);
  assign arith_sel_o = is_arith & bit30_i & (funct3_i == F3_SR);

  always_comb begin
    xop_o     = XOP_ZERO;
    asrc_o    = ASRC_ZERO;
    bsrc_o    = BSRC_REG;
    illegal_o = 1'b0;
    if (is_arith) begin
      asrc_o = ASRC_REG;
      bsrc_o = is_reg ? BSRC_REG : BSRC_IMM_I;
      unique case (funct3_i)
        F3_ADD:  xop_o = sub_sel_o ? XOP_SUB : XOP_ADD;
        F3_SLL:  xop_o = XOP_SLL;
        F3_SLT:  xop_o = XOP_SLT;
        F3_SLTU: xop_o = XOP_SLTU;
        F3_XOR:  xop_o = XOP_XOR;
        F3_SR:   xop_o = arith_sel_o ? XOP_SRA : XOP_SRL;
        F3_OR:   xop_o = XOP_OR;
        F3_AND:  xop_o = XOP_AND;
        default: xop_o = XOP_ZERO;
      endcase
    end else if (opcode_i == OPC_LUI) begin
      xop_o  = XOP_ADD;
      asrc_o = ASRC_ZERO;
      bsrc_o = BSRC_IMM_U;
    end else if (opcode_i == OPC_AUIPC) begin
      xop_o  = XOP_ADD;
      asrc_o = ASRC_PC;
      bsrc_o = BSRC_IMM_U;
    end else begin
      illegal_o = 1'b1;
    end
  end

endmodule

// File: rtl/iexu_imm_gen.sv
module iexu_imm_gen
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [ILEN-1:0] insn_i,
  output logic [XLEN-1:0] imm_i_o,
  output logic [XLEN-1:0] imm_u_o
);

  localparam int unsigned IW_I   = 12;
  localparam int unsigned IW_U   = 20;
  localparam int unsigned ULOW_W = ILEN - IW_U;

  assign imm_i_o = {{(XLEN-IW_I){insn_i[ILEN-1]}}, insn_i[ILEN-1 -: IW_I]};

  generate
    if (XLEN > ILEN) begin : g_wide
      assign imm_u_o = {{(XLEN-ILEN){insn_i[ILEN-1]}},
                        insn_i[ILEN-1 -: IW_U], {ULOW_W{1'b0}}};
    end else begin : g_native
      assign imm_u_o = {insn_i[ILEN-1 -: IW_U], {ULOW_W{1'b0}}};
    end
  endgenerate

endmodule

// File: rtl/iexu_core.sv
module iexu_core
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  xop_e            xop_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);

  localparam int unsigned SHW = $clog2(XLEN);

  function automatic logic [XLEN-1:0] f_addsub(input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b,
                                               input logic sub);
    logic [XLEN-1:0] bb;
    bb = sub ? ~b : b;
    return a + bb + {{(XLEN-1){1'b0}}, sub};
  endfunction

  function automatic logic [XLEN-1:0] f_shift(input logic [XLEN-1:0] a,
                                              input logic [SHW-1:0]  amt,
                                              input logic right,
                                              input logic arith);
    logic [XLEN-1:0] r;
    if (!right)     r = a << amt;
    else if (arith) r = $unsigned($signed(a) >>> amt);
    else            r = a >> amt;
    return r;
  endfunction

  function automatic logic f_less(input logic [XLEN-1:0] a,
                                  input logic [XLEN-1:0] b,
                                  input logic signed_cmp);
    return signed_cmp ? ($signed(a) < $signed(b)) : (a < b);
  endfunction

  logic [SHW-1:0] amt;
  assign amt = b_i[SHW-1:0];

  always_comb begin
    unique case (xop_i)
      XOP_ADD:  y_o = f_addsub(a_i, b_i, 1'b0);
      XOP_SUB:  y_o = f_addsub(a_i, b_i, 1'b1);
      XOP_SLL:  y_o = f_shift(a_i, amt, 1'b0, 1'b0);
      XOP_SRL:  y_o = f_shift(a_i, amt, 1'b1, 1'b0);
      XOP_SRA:  y_o = f_shift(a_i, amt, 1'b1, 1'b1);
      XOP_SLT:  y_o = {{(XLEN-1){1'b0}}, f_less(a_i, b_i, 1'b1)};
      XOP_SLTU: y_o = {{(XLEN-1){1'b0}}, f_less(a_i, b_i, 1'b0)};
      XOP_XOR:  y_o = a_i ^ b_i;
      XOP_OR:   y_o = a_i | b_i;
      XOP_AND:  y_o = a_i & b_i;
      default:  y_o = '0;
    endcase
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic            bit30_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [31:0]     insn_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);

  xop_e            xop;
  asrc_e           asrc;
  bsrc_e           bsrc;
  logic            sub_sel;
  logic            arith_sel;
  logic [XLEN-1:0] imm_i, imm_u;
  logic [XLEN-1:0] op_a, op_b;

  iexu_decode u_decode (
    .opcode_i    (opcode_i),
    .funct3_i    (funct3_i),
    .bit30_i     (bit30_i),
    .xop_o       (xop),
    .asrc_o      (asrc),
    .bsrc_o      (bsrc),
    .sub_sel_o   (sub_sel),
    .arith_sel_o (arith_sel),
    .illegal_o   (illegal_o)
  );

  iexu_imm_gen #(.XLEN(XLEN)) u_imm (
    .insn_i  (insn_i),
    .imm_i_o (imm_i),
    .imm_u_o (imm_u)
  );

  always_comb begin
    unique case (asrc)
      ASRC_REG: op_a = rs1_val_i;
      ASRC_PC:  op_a = pc_i;
      default:  op_a = '0;
    endcase
    unique case (bsrc)
      BSRC_IMM_I: op_b = imm_i;
      BSRC_IMM_U: op_b = imm_u;
      default:    op_b = rs2_val_i;
    endcase
  end

  iexu_core #(.XLEN(XLEN)) u_core (
    .xop_i (xop),
    .a_i   (op_a),
    .b_i   (op_b),
    .y_o   (result_o)
  );

endmodule

// File: rtl/iexu_checker.sv
module iexu_checker
  import iexu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic [6:0]      opcode_i,
  input logic [2:0]      funct3_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] rs2_val_i,
  input logic [XLEN-1:0] pc_i,
  input logic [31:0]     insn_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o,
  input logic            sub_sel,
  input logic            arith_sel
);

  localparam int unsigned SHW = $clog2(XLEN);

  logic           legal_opc, is_shift;
  logic [SHW-1:0] shamt;

  assign legal_opc = (opcode_i == OPC_REG) || (opcode_i == OPC_IMM) ||
                     (opcode_i == OPC_LUI) || (opcode_i == OPC_AUIPC);
  assign is_shift  = ((opcode_i == OPC_REG) || (opcode_i == OPC_IMM)) &&
                     ((funct3_i == F3_SLL) || (funct3_i == F3_SR));
  assign shamt     = (opcode_i == OPC_REG) ? rs2_val_i[SHW-1:0] : insn_i[20 +: SHW];

  always_comb begin
    AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0)
      else $error("illegal opcode gave nonzero result"); // R9
    AST_LEGAL_FLAG: assert (illegal_o == !legal_opc)
      else $error("illegal flag disagrees with opcode"); // R9
    AST_IMM_NO_SUB: assert (!(opcode_i == OPC_IMM && sub_sel))
      else $error("subtract selected in immediate form"); // R3
    AST_SLT_BOOL: assert (!(((opcode_i == OPC_REG) || (opcode_i == OPC_IMM)) &&
                            ((funct3_i == F3_SLT) || (funct3_i == F3_SLTU))) ||
                          result_o[XLEN-1:1] == '0)
      else $error("compare result not 0/1"); // R6
    AST_SHIFT_ZERO: assert (!(is_shift && shamt == '0) || result_o == rs1_val_i)
      else $error("zero shift altered operand"); // R4
    AST_SRA_SIGN: assert (!(arith_sel && rs1_val_i[XLEN-1]) || result_o[XLEN-1])
      else $error("arithmetic shift lost sign"); // R5
    AST_LUI_LOW: assert (!(opcode_i == OPC_LUI) || result_o[11:0] == '0)
      else $error("upper immediate low bits nonzero"); // R7
    AST_AUIPC_LOW: assert (!(opcode_i == OPC_AUIPC) || result_o[11:0] == pc_i[11:0])
      else $error("pc-relative low bits differ from pc"); // R8
  end

endmodule

bind int_exec_unit iexu_checker #(.XLEN(XLEN)) u_chk (
  .opcode_i  (opcode_i),
  .funct3_i  (funct3_i),
  .rs1_val_i (rs1_val_i),
  .rs2_val_i (rs2_val_i),
  .pc_i      (pc_i),
  .insn_i    (insn_i),
  .result_o  (result_o),
  .illegal_o (illegal_o),
  .sub_sel   (sub_sel),
  .arith_sel (arith_sel)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

  localparam logic [6:0] K_REG = 7'h33;
  localparam logic [6:0] K_IMM = 7'h13;
  localparam logic [6:0] K_LUI = 7'h37;
  localparam logic [6:0] K_AUI = 7'h17;
  localparam int NV = 34;
  localparam int NRAND = 400;

  typedef struct packed {
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [11:0] hi;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] pc;
    logic [31:0] exp;
    logic        ill;
  } vec_t;

  // insn is built as {hi, 5'd3, f3, 5'd5, opc}; bit30 = hi[10]
  localparam vec_t VECS [NV] = '{
    '{K_REG, 3'd0, 12'h000, 32'd5,        32'd7,        32'd0, 32'd12,        1'b0}, // R1 add
    '{K_REG, 3'd0, 12'h400, 32'd5,        32'd7,        32'd0, 32'hFFFFFFFE,  1'b0}, // R2 sub
    '{K_REG, 3'd0, 12'h000, 32'hFFFFFFFF, 32'd1,        32'd0, 32'h00000000,  1'b0}, // R10 add wrap
    '{K_REG, 3'd0, 12'h400, 32'h80000000, 32'd1,        32'd0, 32'h7FFFFFFF,  1'b0}, // R10 sub wrap
    '{K_REG, 3'd1, 12'h000, 32'd1,        32'h25,       32'd0, 32'h00000020,  1'b0}, // R4 sll low5
    '{K_REG, 3'd2, 12'h000, 32'hFFFFFFFF, 32'd1,        32'd0, 32'd1,         1'b0}, // R6 slt
    '{K_REG, 3'd3, 12'h000, 32'hFFFFFFFF, 32'd1,        32'd0, 32'd0,         1'b0}, // R6 sltu
    '{K_REG, 3'd4, 12'h000, 32'hF0F0F0F0, 32'hFF00FF00, 32'd0, 32'h0FF00FF0,  1'b0}, // R1 xor
    '{K_REG, 3'd5, 12'h000, 32'h80000000, 32'd4,        32'd0, 32'h08000000,  1'b0}, // R5 srl
    '{K_REG, 3'd5, 12'h400, 32'h80000000, 32'd4,        32'd0, 32'hF8000000,  1'b0}, // R5 sra
    '{K_REG, 3'd6, 12'h000, 32'hF0F0F0F0, 32'h0F0F0000, 32'd0, 32'hFFFFF0F0,  1'b0}, // R1 or
    '{K_REG, 3'd7, 12'h000, 32'hF0F0F0F0, 32'hFF00FF00, 32'd0, 32'hF000F000,  1'b0}, // R1 and
    '{K_REG, 3'd1, 12'h000, 32'hDEADBEEF, 32'h20,       32'd0, 32'hDEADBEEF,  1'b0}, // R4 sll by 0
    '{K_IMM, 3'd0, 12'hFFF, 32'd10,       32'd99,       32'd0, 32'd9,         1'b0}, // R3 addi -1
    '{K_IMM, 3'd0, 12'h400, 32'd1,        32'd99,       32'd0, 32'h00000401,  1'b0}, // R3 addi bit10
    '{K_IMM, 3'd2, 12'h800, 32'd0,        32'd0,        32'd0, 32'd0,         1'b0}, // R6 slti
    '{K_IMM, 3'd2, 12'h800, 32'hFFFFF000, 32'd0,        32'd0, 32'd1,         1'b0}, // R6 slti neg
    '{K_IMM, 3'd3, 12'hFFF, 32'd5,        32'd0,        32'd0, 32'd1,         1'b0}, // R6 sltiu sext
    '{K_IMM, 3'd3, 12'h005, 32'hFFFFFFFF, 32'd0,        32'd0, 32'd0,         1'b0}, // R6 sltiu
    '{K_IMM, 3'd4, 12'hFFF, 32'h12345678, 32'd0,        32'd0, 32'hEDCBA987,  1'b0}, // R3 xori
    '{K_IMM, 3'd6, 12'h0F0, 32'h00000100, 32'd0,        32'd0, 32'h000001F0,  1'b0}, // R1 ori
    '{K_IMM, 3'd7, 12'h800, 32'hFFFFFFFF, 32'd0,        32'd0, 32'hFFFFF800,  1'b0}, // R3 andi
    '{K_IMM, 3'd1, 12'h01F, 32'd1,        32'd0,        32'd0, 32'h80000000,  1'b0}, // R4 slli 31
    '{K_IMM, 3'd5, 12'h008, 32'hF0000000, 32'd0,        32'd0, 32'h00F00000,  1'b0}, // R5 srli
    '{K_IMM, 3'd5, 12'h408, 32'hF0000000, 32'd0,        32'd0, 32'hFFF00000,  1'b0}, // R5 srai
    '{K_IMM, 3'd5, 12'h400, 32'h80000001, 32'd0,        32'd0, 32'h80000001,  1'b0}, // R4 srai by 0
    '{K_REG, 3'd5, 12'h400, 32'h80000001, 32'hFFFFFFE0, 32'd0, 32'h80000001,  1'b0}, // R4 sra by 0
    '{K_LUI, 3'd0, 12'h123, 32'hAAAAAAAA, 32'h55555555, 32'h44, 32'h12318000, 1'b0}, // R7
    '{K_LUI, 3'd0, 12'hFFF, 32'd1,        32'd2,        32'h44, 32'hFFF18000, 1'b0}, // R7
    '{K_AUI, 3'd0, 12'h001, 32'd7,        32'd7,        32'h00001000, 32'h00119000, 1'b0}, // R8
    '{K_AUI, 3'd0, 12'hFFF, 32'd7,        32'd7,        32'h00010004, 32'hFFF28004, 1'b0}, // R8
    '{7'h03, 3'd0, 12'h000, 32'd5,        32'd7,        32'd0, 32'd0,         1'b1}, // R9
    '{7'h63, 3'd1, 12'h7FF, 32'd5,        32'd7,        32'd9, 32'd0,         1'b1}, // R9
    '{7'h33 ^ 7'h40, 3'd0, 12'h000, 32'd5, 32'd7,       32'd0, 32'd0,         1'b1}  // R9
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode;
  logic [2:0]  funct3;
  logic        bit30;
  logic [31:0] rs1, rs2, pc, insn;
  logic [31:0] result;
  logic        illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  int_exec_unit dut_i (
    .opcode_i  (opcode),
    .funct3_i  (funct3),
    .bit30_i   (bit30),
    .rs1_val_i (rs1),
    .rs2_val_i (rs2),
    .pc_i      (pc),
    .insn_i    (insn),
    .result_o  (result),
    .illegal_o (illegal)
  );

  // Independent model: bit-serial shifts, offset-binary compare, 33-bit sums.
  function automatic logic [32:0] ref_model(input logic [31:0] w, input logic [31:0] a,
                                            input logic [31:0] b, input logic [31:0] p);
    logic [31:0] opb, r, t;
    logic [32:0] s;
    int n;
    r = 32'd0;
    if (w[6:0] == K_LUI) return {1'b0, w[31:12], 12'd0};
    if (w[6:0] == K_AUI) begin
      s = {1'b0, p} + {1'b0, w[31:12], 12'd0};
      return {1'b0, s[31:0]};
    end
    if (w[6:0] != K_REG && w[6:0] != K_IMM) return {1'b1, 32'd0};
    opb = (w[6:0] == K_REG) ? b : {{20{w[31]}}, w[31:20]};
    n = int'(opb[4:0]);
    case (w[14:12])
      3'd0: begin
        if (w[6:0] == K_REG && w[30]) s = {1'b0, a} + {1'b0, ~opb} + 33'd1;
        else                          s = {1'b0, a} + {1'b0, opb};
        r = s[31:0];
      end
      3'd1: begin t = a; for (int i = 0; i < n; i++) t = {t[30:0], 1'b0}; r = t; end
      3'd2: r = {31'd0, (a ^ 32'h80000000) < (opb ^ 32'h80000000)};
      3'd3: r = {31'd0, a < opb};
      3'd4: r = a ^ opb;
      3'd5: begin
        t = a;
        for (int i = 0; i < n; i++) t = {(w[30] ? t[31] : 1'b0), t[31:1]};
        r = t;
      end
      3'd6: r = a | opb;
      default: r = a & opb;
    endcase
    return {1'b0, r};
  endfunction

  task automatic drive(input logic [31:0] w, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] p);
    @(posedge clk);
    insn   = w;
    opcode = w[6:0];
    funct3 = w[14:12];
    bit30  = w[30];
    rs1    = a;
    rs2    = b;
    pc     = p;
    @(negedge clk);
  endtask

  task automatic compare(input string tag, input logic [31:0] exp_r, input logic exp_i);
    checks++;
    if (result !== exp_r || illegal !== exp_i) begin
      fails++;
      $display("FAIL %s: result=%08h illegal=%0b expected result=%08h illegal=%0b",
               tag, result, illegal, exp_r, exp_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [32:0] m;
    logic [31:0] w;
    insn = '0; opcode = '0; funct3 = '0; bit30 = 1'b0;
    rs1 = '0; rs2 = '0; pc = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle all-zero inputs: opcode 0 is not handled, so R9 applies.
    compare("R9 idle", 32'd0, 1'b1);

    for (int k = 0; k < NV; k++) begin
      drive({VECS[k].hi, 5'd3, VECS[k].f3, 5'd5, VECS[k].opc},
            VECS[k].a, VECS[k].b, VECS[k].pc);
      compare($sformatf("vector %0d (R1..R10 table)", k), VECS[k].exp, VECS[k].ill);
    end

    // R3 and R5 together: immediate bit 10 set on an add keeps adding,
    // the same bit on a right shift selects arithmetic fill.
    drive({12'hC00, 5'd3, 3'd0, 5'd5, K_IMM}, 32'h00001000, 32'd0, 32'd0);
    compare("R3 addi imm=0xC00", 32'h00000C00, 1'b0);
    drive({12'h41F, 5'd3, 3'd5, 5'd5, K_IMM}, 32'h80000000, 32'd0, 32'd0);
    compare("R5 srai 31", 32'hFFFFFFFF, 1'b0);

    // Random sweep across all four families, R1..R8 and R10 via model.
    for (int k = 0; k < NRAND; k++) begin
      w = $urandom;
      case (k % 5)
        0: w = {1'b0, w[30], 5'd0, w[24:7], K_REG};
        1, 2: w = {w[31:7], K_IMM};
        3: w = {w[31:7], (w[7] ? K_LUI : K_AUI)};
        default: w = {w[31:7], 5'b00100, w[1:0]};
      endcase
      if (k % 5 == 1 && w[14:12] == 3'd1) w[30] = 1'b0;
      drive(w, $urandom, (k % 7 == 0) ? 32'h80000000 : $urandom, $urandom);
      m = ref_model(w, rs1, rs2, pc);
      compare($sformatf("random %0d insn=%08h R1 R8 R10", k, w), m[31:0], m[32]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule